// File: doc/BRIEF.md
# Global-Clock Emulated Write-Port RAM

This block is a small RAM whose single write port behaves as if it were clocked by its own write clock, with a selectable active edge, while every storage element is actually updated by one global sampling clock. The write clock is never used as a clock. It is sampled like data. A previous-sample register for the write clock, together with the live level, identifies an active edge. The write mask, write address and write data are captured once per global cycle, and a write is committed with those captured values only in the global cycle where an active write-clock edge is seen.

The block lets logic that was built around a slow or separate write clock live inside a single-clock region, such as a formal or emulation environment with one implicit clock. The global clock must sample each write-clock phase at least once. One asynchronous read port returns the word at its own address in the same cycle. A read port with its own clock is not supported. Choosing that configuration stops elaboration.

Top module: `gcw_mem`

## Requirements
- R1: A synchronous active-high reset clears every word to zero, clears the captured mask, address and data, and loads the write-clock previous-sample register with the active level: 1 for rising-edge ports and 0 for falling-edge ports. A write clock held at that level after reset therefore commits nothing.
- R2: The parameter WR_EDGE selects the active edge. EDGE_RISE (1) commits when the previous sample is 0 and the live write clock is 1. EDGE_FALL (0) commits when the previous sample is 1 and the live level is 0.
- R3: A commit uses the mask, address and data that were sampled at the global edge one cycle before the committing edge, not the live inputs.
- R4: In a global cycle with no active edge, the effective write mask is all zeros and no word changes, whatever the mask input holds.
- R5: Bit i of the mask governs bit i of the data word. Stored bits whose mask bit is 0 keep their old value.
- R6: A read of the address being committed returns the old contents up to the committing global edge, and the new contents from the following cycle on.
- R7: The read port is combinational: rdata follows raddr within the same global cycle. Setting RD_MODE to READ_CLOCKED (1) is refused at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gclk | input | 1 | Global sampling clock; the only clock of the block |
| rst | input | 1 | Synchronous active-high reset |
| wclk | input | 1 | Emulated write clock, sampled as data |
| wmask | input | WIDTH | Per-bit write enable |
| waddr | input | AW | Write address, AW = clog2(DEPTH) |
| wdata | input | WIDTH | Write data |
| raddr | input | AW | Asynchronous read address |
| rdata | output | WIDTH | Word stored at raddr |

## Verification
The bench drives a rising-edge and a falling-edge instance from the same stimulus and keeps a reference memory that is updated on each write-clock edge from the inputs present before that edge. The bench goes after several corner cases. A write clock held at its active level through reset would make a design with the wrong previous-sample reset value write spurious data. Data and address that change together with the clock edge expose a design that commits the live inputs instead of the captured ones. Partial masks expose a design that writes whole words. Reading the address being written in the committing cycle exposes forwarding of new data a cycle early. Random mask, address, data and write-clock phase lengths of one to three global cycles shake out the remaining disagreements with the reference.

// File: rtl/gcw_pkg.sv
`timescale 1ns/1ps
package gcw_pkg;

    // Active edge of the emulated write clock
    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } wedge_e;

    // Read port style; only the combinational one is accepted
    typedef enum logic {
        READ_COMB    = 1'b0,
        READ_CLOCKED = 1'b1
    } rdmode_e;

    // Level the previous-sample register takes at reset
    function automatic logic rest_level(input wedge_e pol);
        return (pol == EDGE_RISE);
    endfunction

    // Edge pattern match on (previous sample, live sample)
    function automatic logic edge_hit(input logic prev, input logic now, input wedge_e pol);
        if (pol == EDGE_RISE)
            return (!prev && now);
        else
            return (prev && !now);
    endfunction

endpackage

// File: rtl/gcw_edge_sense.sv
`timescale 1ns/1ps
module gcw_edge_sense
    import gcw_pkg::*;
#(
    parameter wedge_e POL = EDGE_RISE
) (
    input  logic gclk,
    input  logic rst,
    input  logic wclk,
    output logic fire,
    output logic prev_q
);

    always_ff @(posedge gclk) begin
        if (rst)
            prev_q <= rest_level(POL);
        else
            prev_q <= wclk;
    end

    assign fire = edge_hit(prev_q, wclk, POL);

endmodule

// File: rtl/gcw_wr_stage.sv
`timescale 1ns/1ps
module gcw_wr_stage #(
    parameter int WIDTH = 8,
    parameter int AW    = 4
) (
    input  logic             gclk,
    input  logic             rst,
    input  logic [WIDTH-1:0] mask_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             fire,
    output logic [WIDTH-1:0] eff_mask,
    output logic [AW-1:0]    addr_q,
    output logic [WIDTH-1:0] data_q
);

    typedef struct packed {
        logic [WIDTH-1:0] mask;
        logic [AW-1:0]    addr;
        logic [WIDTH-1:0] data;
    } wreq_t;

    wreq_t req_d, req_q;

    always_comb begin
        req_d.mask = mask_i;
        req_d.addr = addr_i;
        req_d.data = data_i;
    end

    always_ff @(posedge gclk) begin
        if (rst)
            req_q <= '0;
        else
            req_q <= req_d;
    end

    assign eff_mask = fire ? req_q.mask : '0;
    assign addr_q   = req_q.addr;
    assign data_q   = req_q.data;

endmodule

// File: rtl/gcw_store.sv
`timescale 1ns/1ps
module gcw_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    parameter int AW    = 4
) (
    input  logic             gclk,
    input  logic             rst,
    input  logic [WIDTH-1:0] wmask,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    localparam bit FULL_MAP = (DEPTH == (1 << AW));

    logic [WIDTH-1:0] rd_vec [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        logic             hit;
        logic [WIDTH-1:0] word_q;

        assign hit = (waddr == AW'(i)) && (wmask != '0);

        always_ff @(posedge gclk) begin
            if (rst)
                word_q <= '0;
            else if (hit)
                word_q <= (word_q & ~wmask) | (wdata & wmask);
        end

        assign rd_vec[i] = word_q;
    end

    if (FULL_MAP) begin : g_rd_full
        assign rdata = rd_vec[raddr];
    end else begin : g_rd_guard
        assign rdata = (int'(raddr) < DEPTH) ? rd_vec[raddr] : '0;
    end

endmodule

// File: rtl/gcw_mem.sv
`timescale 1ns/1ps
module gcw_mem
    import gcw_pkg::*;
#(
    parameter int      DEPTH   = 16,
    parameter int      WIDTH   = 8,
    parameter wedge_e  WR_EDGE = EDGE_RISE,
    parameter rdmode_e RD_MODE = READ_COMB,
    localparam int     AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             gclk,
    input  logic             rst,
    input  logic             wclk,
    input  logic [WIDTH-1:0] wmask,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    if (RD_MODE != READ_COMB) begin : g_reject_rd
        $error("gcw_mem: a clocked read port cannot be emulated; use READ_COMB");
    end

    logic             edge_fire;
    logic             wclk_prev;
    logic [WIDTH-1:0] eff_mask;
    logic [AW-1:0]    addr_q;
    logic [WIDTH-1:0] data_q;

    gcw_edge_sense #(
        .POL (WR_EDGE)
    ) u_edge (
        .gclk   (gclk),
        .rst    (rst),
        .wclk   (wclk),
        .fire   (edge_fire),
        .prev_q (wclk_prev)
    );

    gcw_wr_stage #(
        .WIDTH (WIDTH),
        .AW    (AW)
    ) u_stage (
        .gclk     (gclk),
        .rst      (rst),
        .mask_i   (wmask),
        .addr_i   (waddr),
        .data_i   (wdata),
        .fire     (edge_fire),
        .eff_mask (eff_mask),
        .addr_q   (addr_q),
        .data_q   (data_q)
    );

    gcw_store #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH),
        .AW    (AW)
    ) u_store (
        .gclk  (gclk),
        .rst   (rst),
        .wmask (eff_mask),
        .waddr (addr_q),
        .wdata (data_q),
        .raddr (raddr),
        .rdata (rdata)
    );

endmodule

module gcw_mem_chk
    import gcw_pkg::*;
#(
    parameter int     WIDTH   = 8,
    parameter int     AW      = 4,
    parameter wedge_e WR_EDGE = EDGE_RISE
) (
    input logic             gclk,
    input logic             rst,
    input logic             wclk,
    input logic [WIDTH-1:0] wmask,
    input logic [AW-1:0]    waddr,
    input logic [WIDTH-1:0] wdata,
    input logic [AW-1:0]    raddr,
    input logic [WIDTH-1:0] rdata,
    input logic             prev_level
);

    logic             c_prev;
    logic [WIDTH-1:0] c_mask;
    logic [AW-1:0]    c_addr;
    logic [WIDTH-1:0] c_data;
    logic             c_fire;

    always_ff @(posedge gclk) begin
        if (rst) begin
            c_prev <= rest_level(WR_EDGE);
            c_mask <= '0;
            c_addr <= '0;
            c_data <= '0;
        end else begin
            c_prev <= wclk;
            c_mask <= wmask;
            c_addr <= waddr;
            c_data <= wdata;
        end
    end

    assign c_fire = edge_hit(c_prev, wclk, WR_EDGE);

    AST_RESET_CLEAR: assert property (@(posedge gclk)
        rst |=> (rdata == '0)); // R1

    AST_PREV_INIT: assert property (@(posedge gclk)
        rst |=> (prev_level == rest_level(WR_EDGE))); // R1

    AST_HOLD_WITHOUT_EDGE: assert property (@(posedge gclk) disable iff (rst)
        !c_fire |=> ((raddr != $past(raddr)) || (rdata == $past(rdata)))); // R4

    AST_WRITE_CAPTURED: assert property (@(posedge gclk) disable iff (rst)
        (c_fire && (raddr == c_addr)) |=>
            ((raddr != $past(raddr)) || (((rdata ^ $past(c_data)) & $past(c_mask)) == '0))); // R3

    AST_MASK_KEEPS: assert property (@(posedge gclk) disable iff (rst)
        (c_fire && (raddr == c_addr)) |=>
            ((raddr != $past(raddr)) || (((rdata ^ $past(rdata)) & ~$past(c_mask)) == '0))); // R5

endmodule

bind gcw_mem gcw_mem_chk #(
    .WIDTH   (WIDTH),
    .AW      (AW),
    .WR_EDGE (WR_EDGE)
) u_chk (
    .gclk       (gclk),
    .rst        (rst),
    .wclk       (wclk),
    .wmask      (wmask),
    .waddr      (waddr),
    .wdata      (wdata),
    .raddr      (raddr),
    .rdata      (rdata),
    .prev_level (wclk_prev)
);

// File: tb/gcw_mem_tb.sv
`timescale 1ns/1ps
module gcw_mem_tb;
    import gcw_pkg::*;

    localparam int DEPTH = 16;
    localparam int W     = 8;
    localparam int AW    = 4;

    logic          gclk = 1'b0;
    logic          rst  = 1'b1;
    logic          wclk = 1'b1;
    logic [W-1:0]  wmask = '0;
    logic [AW-1:0] waddr = '0;
    logic [W-1:0]  wdata = '0;
    logic [AW-1:0] raddr = '0;
    logic [W-1:0]  rdata_r, rdata_f;

    always #2.5 gclk = ~gclk;

    gcw_mem #(.DEPTH(DEPTH), .WIDTH(W), .WR_EDGE(EDGE_RISE)) u_dut (
        .gclk(gclk), .rst(rst), .wclk(wclk), .wmask(wmask), .waddr(waddr),
        .wdata(wdata), .raddr(raddr), .rdata(rdata_r));

    gcw_mem #(.DEPTH(DEPTH), .WIDTH(W), .WR_EDGE(EDGE_FALL)) u_dut_fall (
        .gclk(gclk), .rst(rst), .wclk(wclk), .wmask(wmask), .waddr(waddr),
        .wdata(wdata), .raddr(raddr), .rdata(rdata_f));

    typedef struct {
        logic [AW-1:0] a;
        logic [W-1:0]  er;
        logic [W-1:0]  ef;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // reference state
    logic [W-1:0]  ref_r [DEPTH];
    logic [W-1:0]  ref_f [DEPTH];
    logic          prev_r, prev_f;
    logic [W-1:0]  last_m, last_d;
    logic [AW-1:0] last_a;
    logic          pend_r, pend_f;
    logic [W-1:0]  pm, pd;
    logic [AW-1:0] pa;

    task automatic step(input logic r, input logic wv, input logic [W-1:0] m,
                        input logic [AW-1:0] a, input logic [W-1:0] d,
                        input logic [AW-1:0] ra, input string tag);
        @(posedge gclk);
        #1;
        if (pend_r) ref_r[pa] = (ref_r[pa] & ~pm) | (pd & pm);
        if (pend_f) ref_f[pa] = (ref_f[pa] & ~pm) | (pd & pm);
        pend_r = 1'b0;
        pend_f = 1'b0;
        rst = r; wclk = wv; wmask = m; waddr = a; wdata = d; raddr = ra;
        if (r) begin
            for (int i = 0; i < DEPTH; i++) begin
                ref_r[i] = '0;
                ref_f[i] = '0;
            end
            prev_r = 1'b1;
            prev_f = 1'b0;
            last_m = '0; last_a = '0; last_d = '0;
        end else begin
            pend_r = !prev_r && wv;
            pend_f = prev_f && !wv;
            pm = last_m; pa = last_a; pd = last_d;
            prev_r = wv; prev_f = wv;
            last_m = m; last_a = a; last_d = d;
            q.push_back('{a: ra, er: ref_r[ra], ef: ref_f[ra], tag: tag});
        end
    endtask

    // monitor: compares one queued item per global cycle
    initial begin
        forever begin
            @(negedge gclk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_cmp++;
                if (rdata_r !== e.er) begin
                    n_bad++;
                    $display("FAIL %s rising addr=%0d got=%02h exp=%02h", e.tag, e.a, rdata_r, e.er);
                end
                n_cmp++;
                if (rdata_f !== e.ef) begin
                    n_bad++;
                    $display("FAIL %s falling addr=%0d got=%02h exp=%02h", e.tag, e.a, rdata_f, e.ef);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        pend_r = 1'b0; pend_f = 1'b0;
        // R1: reset with write clock held high
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 8'hFF, 4'd3, 8'hAA, 4'd3, "R1");
        // R1/R4: clock held high, full mask: neither port commits
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 8'hFF, 4'd3, 8'hAA, 4'd3, "R1");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 8'hFF, 4'(i), 8'h55, 4'(i), "R4");
        // R2: falling edge commits on the falling port only; read same address is old (R6)
        step(1'b0, 1'b1, 8'hFF, 4'd5, 8'hC3, 4'd5, "R4");
        step(1'b0, 1'b0, 8'h00, 4'd9, 8'h11, 4'd5, "R6");
        step(1'b0, 1'b0, 8'h00, 4'd9, 8'h11, 4'd5, "R2");
        // R3: data and address change with the rising edge; the earlier ones commit
        step(1'b0, 1'b0, 8'hFF, 4'd7, 8'h3C, 4'd7, "R3");
        step(1'b0, 1'b1, 8'hFF, 4'd8, 8'h99, 4'd7, "R6");
        step(1'b0, 1'b1, 8'h00, 4'd8, 8'h00, 4'd7, "R3");
        step(1'b0, 1'b1, 8'h00, 4'd8, 8'h00, 4'd8, "R3");
        // R5: partial mask
        step(1'b0, 1'b0, 8'h0F, 4'd7, 8'hF0, 4'd7, "R5");
        step(1'b0, 1'b1, 8'h0F, 4'd7, 8'hF0, 4'd7, "R5");
        step(1'b0, 1'b1, 8'h00, 4'd7, 8'h00, 4'd7, "R5");
        // R7: read address sweep within single cycles, no writes
        for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, 8'h00, 4'd0, 8'h00, 4'(i), "R7");
        // R3/R5/R6: random stimulus, write-clock phases of 1..3 cycles
        begin
            logic lvl;
            lvl = 1'b1;
            for (int p = 0; p < 1500; p++) begin
                int len;
                lvl = ~lvl;
                len = 1 + int'($urandom_range(2));
                for (int k = 0; k < len; k++) begin
                    logic [AW-1:0] a;
                    logic [AW-1:0] ra;
                    a  = AW'($urandom);
                    ra = ($urandom_range(1) == 0) ? a : AW'($urandom);
                    step(1'b0, lvl, W'($urandom), a, W'($urandom), ra, "R3");
                end
            end
        end
        // R1: reset again with the clock low, then hold low
        step(1'b1, 1'b0, 8'hFF, 4'd2, 8'h77, 4'd2, "R1");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 8'hFF, 4'd2, 8'h77, 4'd2, "R1");
        repeat (3) @(posedge gclk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule